// File: doc/BRIEF.md
# Sticky Three-State Output Controller

This block guards every output enable of a design against an active-high three-state request. A short glitch on the request does nothing. The request must stay high for a fixed number of consecutive qualifying clock cycles. Once it has, the block latches. From then on it drives all output enables inactive, which means high impedance at the pads. It also pins a set of internal mode-select lines to a fixed safe pattern. The latch survives everything except the reset input, which stands for power-on reset.

Qualifying cycles come from one of two sources, chosen by a strap that is sampled only while reset is high. If the strap is high, every system clock cycle counts. If it is low, each rising edge of a separate external clock counts. The block brings that clock into the system domain through a synchronizer and detects its edges there. In normal operation the enables and mode lines pass through one register stage.

Top module: `tristate_guard`

## Requirements
- R1: On a clock edge with `rst` high, `oe_out`, `mode_out` and `latched` all become zero.
- R2: While not latched, `oe_out` and `mode_out` equal the `oe_in` and `mode_in` values seen at the previous clock edge.
- R3: With system-clock counting selected, `latched` becomes 1 at the edge where `hiz_req` has been seen high at QUAL_CYCLES (10) consecutive edges.
- R4: If `hiz_req` is seen low at any edge before the latch is set, the count so far is discarded, and a fresh full run of qualifying cycles is needed.
- R5: From the edge after `latched` becomes 1, `oe_out` is all zeros whatever `oe_in` does.
- R6: From the edge after `latched` becomes 1, `mode_out` equals MODE_SAFE whatever `mode_in` does.
- R7: Once set, `latched` stays 1 regardless of `hiz_req`, `oe_in`, `mode_in`, `ext_clk` or `clk_strap`, until `rst` is high at an edge.
- R8: `clk_strap` is sampled only at edges with `rst` high: 1 selects system-clock counting, 0 selects external-clock counting. Changes after reset has been released have no effect until the next reset.
- R9: With external-clock counting, a qualifying cycle is an edge n at which `ext_clk` was seen 1 at edge n-2 and 0 at edge n-3 (two synchronizer stages). `hiz_req` must be high at every edge, not only at the qualifying ones.
- R10: With external-clock counting and `ext_clk` held still, `latched` never rises, however long `hiz_req` stays high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high power-on reset |
| clk_strap | input | 1 | Count-source strap: 1 system clock, 0 external clock; sampled during reset |
| ext_clk | input | 1 | External clock whose rising edges are counted in external mode |
| hiz_req | input | 1 | Active-high three-state request |
| oe_in | input | OE_W | Output enables from the functional logic |
| mode_in | input | MODE_W | Internal mode-select values from the functional logic |
| oe_out | output | OE_W | Registered output enables, forced to zero once latched |
| mode_out | output | MODE_W | Registered mode-select values, forced to MODE_SAFE once latched |
| latched | output | 1 | Status flag: the three-state condition is in force |

## Verification
The bench builds the block with QUAL_CYCLES at 10, two synchronizer stages, eight enables and a four-bit mode bus. MODE_SAFE is set to 4'b0110, so that the forced mode pattern cannot be mistaken for the reset value or for pass-through data. Because the count is only ten, the bench can cover several cases in a short run: a run that stops one cycle short, a full qualifying run, and an interrupted run on an external clock six system cycles long. Keeping the synchronizer at two stages means the bench model can predict each external edge at an exact system-clock edge.

// File: rtl/tsg_pkg.sv
package tsg_pkg;
  typedef enum logic {
    CNT_SRC_EXT = 1'b0,
    CNT_SRC_SYS = 1'b1
  } cnt_src_e;
endpackage

// File: rtl/tsg_strap.sv
module tsg_strap
  import tsg_pkg::*;
(
  input  logic     clk,
  input  logic     rst,
  input  logic     strap,
  output cnt_src_e src_o
);
  cnt_src_e src_q;

  // Strap is captured only while reset is held.
  always_ff @(posedge clk) begin
    if (rst) src_q <= cnt_src_e'(strap);
  end

  assign src_o = src_q;

  // R8: source selection frozen outside reset
  a_r8_strap_hold: assert property (@(posedge clk) disable iff (rst)
    !rst |=> $stable(src_q));
endmodule

// File: rtl/tsg_tick.sv
module tsg_tick
  import tsg_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic     clk,
  input  logic     rst,
  input  cnt_src_e src,
  input  logic     ext_clk,
  output logic     tick_o
);
  logic stage_q [SYNC_STAGES];
  logic prev_q;
  logic ext_rise;

  for (genvar i = 0; i < SYNC_STAGES; i++) begin : g_sync
    if (i == 0) begin : g_first
      always_ff @(posedge clk) begin
        if (rst) stage_q[i] <= 1'b0;
        else     stage_q[i] <= ext_clk;
      end
    end else begin : g_next
      always_ff @(posedge clk) begin
        if (rst) stage_q[i] <= 1'b0;
        else     stage_q[i] <= stage_q[i-1];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) prev_q <= 1'b0;
    else     prev_q <= stage_q[SYNC_STAGES-1];
  end

  assign ext_rise = stage_q[SYNC_STAGES-1] & ~prev_q;

  always_comb begin
    if (src == CNT_SRC_SYS) tick_o = 1'b1;
    else                    tick_o = ext_rise;
  end

  // R9: an external edge yields at most one qualifying cycle
  a_r9_single_tick: assert property (@(posedge clk) disable iff (rst)
    (src == CNT_SRC_EXT && tick_o) |=> !tick_o);
endmodule

// File: rtl/tsg_qual.sv
module tsg_qual #(
  parameter int QUAL_CYCLES = 10
) (
  input  logic clk,
  input  logic rst,
  input  logic req,
  input  logic tick,
  output logic latched_o
);
  localparam int CW = $clog2(QUAL_CYCLES + 1);
  localparam logic [CW-1:0] LAST = CW'(QUAL_CYCLES - 1);

  logic [CW-1:0] cnt_q;
  logic          lat_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
      lat_q <= 1'b0;
    end else if (!lat_q) begin
      if (!req) begin
        cnt_q <= '0;
      end else if (tick) begin
        if (cnt_q == LAST) begin
          lat_q <= 1'b1;
          cnt_q <= '0;
        end else begin
          cnt_q <= cnt_q + CW'(1);
        end
      end
    end
  end

  assign latched_o = lat_q;

  // R7: only reset clears the latch
  a_r7_sticky: assert property (@(posedge clk) disable iff (rst)
    lat_q |=> lat_q);
  // R4: a dropped request discards the partial count
  a_r4_count_clear: assert property (@(posedge clk) disable iff (rst)
    (!req && !lat_q) |=> (cnt_q == '0));
  // R3: latch only rises on a held request, count stays in range
  a_r3_rise_on_req: assert property (@(posedge clk) disable iff (rst)
    $rose(lat_q) |-> $past(req));
  a_r3_cnt_range: assert property (@(posedge clk) disable iff (rst)
    cnt_q < CW'(QUAL_CYCLES));
endmodule

// File: rtl/tristate_guard.sv
module tristate_guard
  import tsg_pkg::*;
#(
  parameter int OE_W        = 8,
  parameter int MODE_W      = 4,
  parameter int QUAL_CYCLES = 10,
  parameter int SYNC_STAGES = 2,
  parameter logic [MODE_W-1:0] MODE_SAFE = '0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clk_strap,
  input  logic              ext_clk,
  input  logic              hiz_req,
  input  logic [OE_W-1:0]   oe_in,
  input  logic [MODE_W-1:0] mode_in,
  output logic [OE_W-1:0]   oe_out,
  output logic [MODE_W-1:0] mode_out,
  output logic              latched
);
  cnt_src_e          src;
  logic              tick;
  logic              lat;
  logic [OE_W-1:0]   oe_q;
  logic [MODE_W-1:0] mode_q;

  tsg_strap u_strap (
    .clk   (clk),
    .rst   (rst),
    .strap (clk_strap),
    .src_o (src)
  );

  tsg_tick #(.SYNC_STAGES(SYNC_STAGES)) u_tick (
    .clk     (clk),
    .rst     (rst),
    .src     (src),
    .ext_clk (ext_clk),
    .tick_o  (tick)
  );

  tsg_qual #(.QUAL_CYCLES(QUAL_CYCLES)) u_qual (
    .clk       (clk),
    .rst       (rst),
    .req       (hiz_req),
    .tick      (tick),
    .latched_o (lat)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      oe_q   <= '0;
      mode_q <= '0;
    end else begin
      oe_q   <= lat ? '0 : oe_in;
      mode_q <= lat ? MODE_SAFE : mode_in;
    end
  end

  assign oe_out   = oe_q;
  assign mode_out = mode_q;
  assign latched  = lat;

  // R5: enables inactive once latched
  a_r5_oe_forced: assert property (@(posedge clk) disable iff (rst)
    latched |=> (oe_out == '0));
  // R6: mode lines pinned once latched
  a_r6_mode_forced: assert property (@(posedge clk) disable iff (rst)
    latched |=> (mode_out == MODE_SAFE));
  // R2: one-register pass-through in normal operation
  a_r2_passthru: assert property (@(posedge clk) disable iff (rst)
    !latched |=> (oe_out == $past(oe_in) && mode_out == $past(mode_in)));
endmodule

// File: tb/test_tristate_guard.sv
`timescale 1ns/1ps
module test_tristate_guard;
  localparam int OE_W = 8;
  localparam int MODE_W = 4;
  localparam int QUAL = 10;
  localparam logic [MODE_W-1:0] SAFE = 4'b0110;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic clk_strap = 1'b1;
  logic ext_clk = 1'b0;
  logic hiz_req = 1'b0;
  logic [OE_W-1:0] oe_in = '0;
  logic [MODE_W-1:0] mode_in = '0;
  logic [OE_W-1:0] oe_out;
  logic [MODE_W-1:0] mode_out;
  logic latched;

  int total = 0;
  int fails = 0;

  always #2.5 clk = ~clk;

  tristate_guard #(
    .OE_W(OE_W), .MODE_W(MODE_W), .QUAL_CYCLES(QUAL),
    .SYNC_STAGES(2), .MODE_SAFE(SAFE)
  ) i_tristate_guard (
    .clk(clk), .rst(rst), .clk_strap(clk_strap), .ext_clk(ext_clk),
    .hiz_req(hiz_req), .oe_in(oe_in), .mode_in(mode_in),
    .oe_out(oe_out), .mode_out(mode_out), .latched(latched)
  );

  // Behavioural reference model
  bit m_sys, m_lat, m_started;
  int m_cnt;
  bit x1, x2, x3;
  logic [OE_W-1:0] m_oe;
  logic [MODE_W-1:0] m_mode;

  always @(posedge clk) begin
    bit tk;
    m_started = 1'b1;
    if (rst) begin
      m_sys = clk_strap; m_cnt = 0; m_lat = 0;
      x1 = 0; x2 = 0; x3 = 0; m_oe = '0; m_mode = '0;
    end else begin
      tk = m_sys ? 1'b1 : (x2 && !x3);
      m_oe = m_lat ? '0 : oe_in;
      m_mode = m_lat ? SAFE : mode_in;
      if (!m_lat) begin
        if (!hiz_req) m_cnt = 0;
        else if (tk) begin
          m_cnt++;
          if (m_cnt == QUAL) begin m_lat = 1; m_cnt = 0; end
        end
      end
      x3 = x2; x2 = x1; x1 = ext_clk;
    end
  end

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // Per-cycle comparison against the model
  always @(negedge clk) begin
    if (m_started) begin
      check(oe_out == m_oe, m_lat ? "R5 oe_out" : "R2 oe_out", int'(oe_out), int'(m_oe));
      check(mode_out == m_mode, m_lat ? "R6 mode_out" : "R2 mode_out", int'(mode_out), int'(m_mode));
      check(latched == m_lat, "R3 latched", int'(latched), int'(m_lat));
    end
  end

  // External clock generator: toggles every 3 system cycles when enabled
  bit ext_run = 0;
  int ext_div = 0;
  always @(negedge clk) begin
    if (ext_run) begin
      ext_div++;
      if (ext_div == 3) begin ext_clk <= ~ext_clk; ext_div = 0; end
    end
  end

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic stimulus();
    cyc(3);
    // R1: reset state
    check(oe_out == '0 && mode_out == '0 && latched == 0, "R1 reset state",
          int'({oe_out, mode_out, latched}), 0);
    rst = 0;
    oe_in = 8'hA5; mode_in = 4'h9;
    cyc(2);
    check(oe_out == 8'hA5 && mode_out == 4'h9, "R2 pass-through", int'(oe_out), 'hA5);
    oe_in = 8'h3C; mode_in = 4'h1;
    cyc(1);
    check(oe_out == 8'h3C && mode_out == 4'h1, "R2 pass-through 2", int'(oe_out), 'h3C);
    // R8: strap change after reset ignored (system counting remains)
    clk_strap = 0;
    // R4: nine cycles then drop
    hiz_req = 1; cyc(9); hiz_req = 0;
    cyc(3);
    check(latched == 0, "R4 nine-cycle run no latch", int'(latched), 0);
    hiz_req = 1; cyc(5); hiz_req = 0; cyc(1); hiz_req = 1; cyc(9);
    check(latched == 0, "R4 interrupted run restarts", int'(latched), 0);
    cyc(1);
    check(latched == 1, "R3 latch after ten cycles (R8 strap ignored)", int'(latched), 1);
    cyc(1);
    check(oe_out == '0, "R5 enables forced off", int'(oe_out), 0);
    check(mode_out == SAFE, "R6 mode forced safe", int'(mode_out), int'(SAFE));
    // R7: sticky
    hiz_req = 0; oe_in = 8'hFF; mode_in = 4'hF; clk_strap = 1;
    ext_run = 1;
    cyc(20);
    check(latched == 1 && oe_out == '0, "R7 latch sticky", int'(latched), 1);
    check(mode_out == SAFE, "R7 mode stays safe", int'(mode_out), int'(SAFE));
    ext_run = 0; ext_clk = 0; ext_div = 0;
    // Reset into external mode
    rst = 1; clk_strap = 0; cyc(3);
    check(latched == 0 && oe_out == '0, "R1 reset clears latch", int'(latched), 0);
    rst = 0; clk_strap = 1;
    // R10: external clock still
    hiz_req = 1; cyc(40);
    check(latched == 0, "R10 no ext edges no latch", int'(latched), 0);
    check(oe_out == 8'hFF, "R2 pass-through ext mode", int'(oe_out), 'hFF);
    // R9: interrupted external run
    ext_run = 1; cyc(30);
    hiz_req = 0; cyc(1); hiz_req = 1;
    cyc(40);
    check(latched == 0, "R9 interrupted ext run no latch", int'(latched), 0);
    cyc(40);
    check(latched == 1, "R9 latch on external edges", int'(latched), 1);
    cyc(2);
    check(oe_out == '0 && mode_out == SAFE, "R5 forced in ext mode", int'(oe_out), 0);
    ext_run = 0;
  endtask

  initial begin
    fork
      stimulus();
      begin
        repeat (100000) @(posedge clk);
        fails++; total++;
        $display("FAIL watchdog expired");
      end
    join_any
    disable fork;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule